// File: doc/BRIEF.md
# Shared-Select Die Arbitration Front End

This block sits at the serial input of one die inside a multi-die serial flash package in which every die hangs off the same clock, data-in, data-out and a single common chip-select line. Because no die has a select pin of its own, the choice of which die talks on the bus is made in-band. A dedicated die-select opcode (0xC2) is followed by one byte naming the target die. Every die decodes that command, whatever its current state, and compares the low bits of the target byte with its own strapped identity.

The die whose identity matches becomes the active one when the chip-select line rises at the end of that transaction. Only the active die passes opcodes on to its command engine and is allowed to enable its data-out driver. An inactive die still counts serial bits so that it can find the opcode at the start of each transaction. It does nothing with those bits except watch for a new die-select command. A program or erase already running inside a die is not affected by losing the selection. This lets a read on one die overlap a write on another.

The serial pins are sampled in the block's own clock domain through a short synchronizer. Edges of the serial clock and chip select are detected there.

Top module: `die_select_front`

## Requirements
- R1: After reset, `isSelected` is 1 exactly when `dieIdStrap` is 0. `misoOe`, `cmdStrobe` and `busyOut` are 0.
- R2: A transaction whose first byte is 0xC2, sent MSB first, and whose second byte is a complete ID byte selects this die if the low `ID_W` bits of that byte equal `dieIdStrap`, and deselects it otherwise. The upper bits of the ID byte are ignored.
- R3: A change of selection appears only after `csN` has risen to end the die-select transaction. While `csN` is still low after the ID byte, the previous selection holds.
- R4: A die-select transaction that ends before all 8 bits of the ID byte have arrived leaves the selection unchanged.
- R5: The die-select command is decoded both by the selected die and by deselected dies. A deselected die can therefore be selected again.
- R6: While selected, each non-0xC2 opcode (the first byte of a transaction) appears on `cmdOpcode` with a one-cycle `cmdStrobe`. While deselected, `cmdStrobe` never pulses.
- R7: `misoOe` is 1 only when `csN` is low, the die is selected and `engDriveReq` is 1. Otherwise it is 0.
- R8: `busyOut` follows `arrayBusy` one clock later whether or not the die is selected. A die-select command is accepted while `arrayBusy` is 1.
- R9: Only the first byte of a transaction is treated as an opcode. A 0xC2 value appearing in a later byte changes no selection and produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, used to oversample the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock, shared by all dies |
| csN | input | 1 | Shared active-low chip select |
| mosi | input | 1 | Serial data in, MSB first |
| dieIdStrap | input | ID_W | Fixed identity of this die |
| engDriveReq | input | 1 | Command engine wants to drive data out |
| arrayBusy | input | 1 | Program/erase sequencer is running |
| isSelected | output | 1 | This die owns the bus |
| misoOe | output | 1 | Output enable of the data-out driver |
| cmdStrobe | output | 1 | One-cycle pulse: new opcode for the command engine |
| cmdOpcode | output | 8 | Opcode that goes with `cmdStrobe` |
| busyOut | output | 1 | Registered copy of `arrayBusy` for the command engine |

## Verification
The bench uses the default parameters: a 2-bit identity, 8-bit bytes, opcode 0xC2 and a two-stage synchronizer. It instantiates two dies on one shared bus, strapped to identities 0 and 2. This makes hand-over of the bus, one-owner output enable, and the ignored upper ID bits (0xFE selects die 2) all observable at the ports. Cut-short ID bytes, a 0xC2 value buried in an address byte, a non-existent identity that leaves no die selected, and selection changes while a die reports busy are all reached with this setup.

// File: rtl/die_sel_pkg.sv
package die_sel_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftBit;   // take one serial bit
    logic clearBits;  // restart the bit counter (chip select idle)
  } dpStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,     // chip select high
    ST_OPCODE,   // collecting first byte
    ST_DIEID,    // collecting target identity byte
    ST_FORWARD,  // opcode handed to engine, rest belongs to engine
    ST_DISCARD   // remaining bytes carry no meaning here
  } frontState_t;

endpackage

// File: rtl/die_sel_sync.sv
module die_sel_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stage[s] <= RESET_VAL;
        end else if (s == 0) begin
          stage[s] <= dIn;
        end else begin
          stage[s] <= stage[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign dOut = stage[STAGES-1];

endmodule

// File: rtl/die_sel_dp.sv
module die_sel_dp
  import die_sel_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic              mosiS,
  output logic              byteDone,
  output logic [BYTE_W-1:0] byteVal
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] shiftReg;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] shiftNext;

  assign shiftNext = {shiftReg[BYTE_W-2:0], mosiS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
      byteDone <= 1'b0;
      byteVal  <= '0;
    end else begin
      byteDone <= 1'b0;
      if (stb.clearBits) begin
        bitCnt <= '0;
      end else if (stb.shiftBit) begin
        shiftReg <= shiftNext;
        if (bitCnt == LAST_BIT) begin
          bitCnt   <= '0;
          byteDone <= 1'b1;
          byteVal  <= shiftNext;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  // R2: a byte needs several serial bits, so completions never come back to back
  a_r2_byte_spacing: assert property (@(posedge clk) disable iff (!rstN)
    byteDone |=> !byteDone);

endmodule

// File: rtl/die_sel_ctrl.sv
module die_sel_ctrl
  import die_sel_pkg::*;
#(
  parameter int ID_W = 2,
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] SEL_OPCODE = 8'hC2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckS,
  input  logic              csNS,
  input  logic              byteDone,
  input  logic [BYTE_W-1:0] byteVal,
  input  logic [ID_W-1:0]   dieIdStrap,
  input  logic              arrayBusy,
  output dpStrobe_t         stb,
  output logic              selected,
  output logic              cmdStrobe,
  output logic [BYTE_W-1:0] cmdOpcode,
  output logic              busyOut
);

  frontState_t state;
  logic        sckPrev;
  logic        csPrev;
  logic        pendValid;
  logic [ID_W-1:0] pendId;
  logic        sckRise;
  logic        csRise;

  assign sckRise = sckS & ~sckPrev;
  assign csRise  = csNS & ~csPrev;

  always_comb begin
    stb.shiftBit  = sckRise & ~csNS;
    stb.clearBits = csNS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      sckPrev   <= 1'b0;
      csPrev    <= 1'b1;
      pendValid <= 1'b0;
      pendId    <= '0;
      selected  <= (dieIdStrap == '0);
      cmdStrobe <= 1'b0;
      cmdOpcode <= '0;
      busyOut   <= 1'b0;
    end else begin
      sckPrev   <= sckS;
      csPrev    <= csNS;
      busyOut   <= arrayBusy;
      cmdStrobe <= 1'b0;

      // commit a completed die-select request when the transaction closes
      if (csRise && pendValid) begin
        selected <= (pendId == dieIdStrap);
      end

      if (csNS) begin
        state     <= ST_IDLE;
        pendValid <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: state <= ST_OPCODE;
          ST_OPCODE: begin
            if (byteDone) begin
              if (byteVal == SEL_OPCODE) begin
                state <= ST_DIEID;
              end else if (selected) begin
                state     <= ST_FORWARD;
                cmdStrobe <= 1'b1;
                cmdOpcode <= byteVal;
              end else begin
                state <= ST_DISCARD;
              end
            end
          end
          ST_DIEID: begin
            if (byteDone) begin
              pendValid <= 1'b1;
              pendId    <= byteVal[ID_W-1:0];
              state     <= ST_DISCARD;
            end
          end
          ST_FORWARD: state <= ST_FORWARD;
          ST_DISCARD: state <= ST_DISCARD;
          default:    state <= ST_IDLE;
        endcase
      end
    end
  end

  // R6: an inactive die never hands opcodes to its engine
  a_r6_no_cmd_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    cmdStrobe |-> selected);

  // R6: opcode hand-off is a single pulse per transaction
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cmdStrobe |=> !cmdStrobe);

  // R3: selection is frozen while chip select stays low
  a_r3_hold_in_txn: assert property (@(posedge clk) disable iff (!rstN)
    (!csNS && $past(!csNS)) |-> $stable(selected));

  // R2: selection moves only right after the end of a transaction
  a_r2_change_at_close: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(selected) |-> $past(csNS && !csPrev));

  // R8: busy is passed on regardless of selection
  a_r8_busy_follow: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (busyOut == $past(arrayBusy)));

endmodule

// File: rtl/die_select_front.sv
module die_select_front
  import die_sel_pkg::*;
#(
  parameter int ID_W = 2,
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] SEL_OPCODE = 8'hC2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sck,
  input  logic              csN,
  input  logic              mosi,
  input  logic [ID_W-1:0]   dieIdStrap,
  input  logic              engDriveReq,
  input  logic              arrayBusy,
  output logic              isSelected,
  output logic              misoOe,
  output logic              cmdStrobe,
  output logic [BYTE_W-1:0] cmdOpcode,
  output logic              busyOut
);

  localparam int PIN_W = 3;
  localparam logic [PIN_W-1:0] PIN_IDLE = 3'b100; // {csN, sck, mosi}

  logic [PIN_W-1:0] pinSync;
  dpStrobe_t        stb;
  logic              byteDone;
  logic [BYTE_W-1:0] byteVal;

  die_sel_sync #(
    .WIDTH(PIN_W), .STAGES(SYNC_STAGES), .RESET_VAL(PIN_IDLE)
  ) uSync (
    .clk(clk), .rstN(rstN), .dIn({csN, sck, mosi}), .dOut(pinSync)
  );

  die_sel_dp #(.BYTE_W(BYTE_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .mosiS(pinSync[0]),
    .byteDone(byteDone), .byteVal(byteVal)
  );

  die_sel_ctrl #(
    .ID_W(ID_W), .BYTE_W(BYTE_W), .SEL_OPCODE(SEL_OPCODE)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .sckS(pinSync[1]), .csNS(pinSync[2]),
    .byteDone(byteDone), .byteVal(byteVal), .dieIdStrap(dieIdStrap),
    .arrayBusy(arrayBusy), .stb(stb), .selected(isSelected),
    .cmdStrobe(cmdStrobe), .cmdOpcode(cmdOpcode), .busyOut(busyOut)
  );

  // raw chip select so the driver releases without synchronizer delay
  assign misoOe = ~csN & isSelected & engDriveReq;

endmodule

// File: tb/die_select_front_test.sv
module die_select_front_test;

  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sck = 1'b0;
  logic csN = 1'b1;
  logic mosi = 1'b0;
  logic engDriveReq = 1'b0;
  logic busyA = 1'b0;
  logic busyB = 1'b0;

  logic selA, oeA, stbA, bsyA;
  logic selB, oeB, stbB, bsyB;
  logic [7:0] opA, opB;

  int checks = 0;
  int failures = 0;
  int peerStrobes = 0;
  logic [7:0] expOps [$];
  bit finished = 0;

  always #2 clk = ~clk; // 250 MHz

  die_select_front uut (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .mosi(mosi),
    .dieIdStrap(2'd0), .engDriveReq(engDriveReq), .arrayBusy(busyA),
    .isSelected(selA), .misoOe(oeA), .cmdStrobe(stbA), .cmdOpcode(opA),
    .busyOut(bsyA)
  );

  die_select_front peer (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .mosi(mosi),
    .dieIdStrap(2'd2), .engDriveReq(engDriveReq), .arrayBusy(busyB),
    .isSelected(selB), .misoOe(oeB), .cmdStrobe(stbB), .cmdOpcode(opB),
    .busyOut(bsyB)
  );

  task automatic checkEq(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // monitor: scoreboard for opcodes handed to the engine of die 0
  always @(negedge clk) begin
    if (rstN && stbA) begin
      checks++;
      if (expOps.size() == 0) begin
        failures++;
        $display("FAIL R6 unexpected strobe actual=%0h expected=none", opA);
      end else begin
        logic [7:0] e;
        e = expOps.pop_front();
        if (opA != e) begin
          failures++;
          $display("FAIL R6 opcode actual=%0h expected=%0h", opA, e);
        end
      end
    end
    if (rstN && stbB) peerStrobes++;
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBits(input logic [7:0] b, input int nBits);
    for (int i = 7; i > 7 - nBits; i--) begin
      mosi = b[i];
      waitClk(HALF);
      sck = 1'b1;
      waitClk(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic openTxn();
    csN = 1'b0;
    waitClk(HALF);
  endtask

  task automatic closeTxn();
    waitClk(HALF);
    csN = 1'b1;
    waitClk(8);
  endtask

  // driver: a full die-select transaction
  task automatic selectDie(input logic [7:0] id);
    openTxn();
    sendBits(8'hC2, 8);
    sendBits(id, 8);
    closeTxn();
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int peerBase;
    waitClk(5);
    // R1 reset state
    checkEq(selA, 1, "R1 die0 selected in reset");
    checkEq(selB, 0, "R1 die2 idle in reset");
    checkEq(oeA, 0, "R1 oe low in reset");
    rstN = 1'b1;
    waitClk(4);
    checkEq(selA, 1, "R1 die0 selected after reset");
    checkEq(selB, 0, "R1 die2 idle after reset");
    checkEq(stbA | stbB, 0, "R1 no strobe after reset");
    checkEq(bsyA, 0, "R1 busyOut low after reset");

    // R6/R7/R9: read with address bytes containing 0xC2 and 0x02
    engDriveReq = 1'b1;
    checkEq(oeA, 0, "R7 oe low while csN high");
    expOps.push_back(8'h03);
    openTxn();
    sendBits(8'h03, 8);
    sendBits(8'hC2, 8);
    sendBits(8'h02, 8);
    checkEq(oeA, 1, "R7 selected die drives");
    checkEq(oeB, 0, "R7 idle die stays off");
    engDriveReq = 1'b0;
    waitClk(1);
    checkEq(oeA, 0, "R7 oe needs engine request");
    engDriveReq = 1'b1;
    closeTxn();
    checkEq(oeA, 0, "R7 oe low after close");
    checkEq(selA, 1, "R9 C2 in later byte ignored die0");
    checkEq(selB, 0, "R9 C2 in later byte ignored die2");

    // R2/R3: select die 2 with upper ID bits set
    openTxn();
    sendBits(8'hC2, 8);
    sendBits(8'hFE, 8);
    waitClk(HALF + 6);
    checkEq(selA, 1, "R3 old selection holds before close");
    checkEq(selB, 0, "R3 new die waits for close");
    closeTxn();
    checkEq(selA, 0, "R2 die0 released");
    checkEq(selB, 1, "R2 upper ID bits ignored, die2 selected");

    // R6/R7/R8 while die 0 is deselected
    busyA = 1'b1;
    peerBase = peerStrobes;
    openTxn();
    sendBits(8'h9F, 8);
    waitClk(4);
    checkEq(oeA, 0, "R7 deselected die off");
    checkEq(oeB, 1, "R7 selected die2 drives");
    closeTxn();
    checkEq(peerStrobes - peerBase, 1, "R6 die2 got its opcode");
    checkEq(bsyA, 1, "R8 busy passes while deselected");

    // R4: cut-short ID byte
    openTxn();
    sendBits(8'hC2, 8);
    sendBits(8'h00, 4);
    closeTxn();
    checkEq(selA, 0, "R4 truncated ID keeps die0 off");
    checkEq(selB, 1, "R4 truncated ID keeps die2 on");
    openTxn();
    sendBits(8'hC2, 8);
    closeTxn();
    checkEq(selB, 1, "R4 opcode-only keeps selection");

    // R5/R8: deselected die 0 selected back while die 2 busy
    busyB = 1'b1;
    selectDie(8'h00);
    checkEq(selA, 1, "R5 deselected die decodes select");
    checkEq(selB, 0, "R8 busy die accepts deselect");
    checkEq(bsyB, 1, "R8 busy still reported");
    busyA = 1'b0;
    busyB = 1'b0;
    waitClk(2);
    checkEq(bsyA, 0, "R8 busy falls");

    // R2: identity with no die selects nobody
    selectDie(8'h01);
    checkEq(selA, 0, "R2 id1 deselects die0");
    checkEq(selB, 0, "R2 id1 leaves die2 off");
    openTxn();
    sendBits(8'h05, 8);
    waitClk(4);
    checkEq(oeA | oeB, 0, "R7 nobody drives");
    closeTxn();

    // R5: back to die 0 and opcode path again
    selectDie(8'h04);
    checkEq(selA, 1, "R5 reselect die0");
    expOps.push_back(8'h0B);
    openTxn();
    sendBits(8'h0B, 8);
    closeTxn();

    waitClk(10);
    checkEq(expOps.size(), 0, "R6 all expected opcodes seen");
    finishRun();
  end

endmodule